// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block lights four seven-segment digits that share one set of segment lines. Only one digit is switched on at a time, and the block steps through the four digits in a fixed ring. For each digit it puts that digit's segment pattern on the shared lines. If the ring steps fast enough, all four digits appear lit at once.

A 16-bit input carries four hexadecimal nibbles, with digit k at bits [4k+3:4k]. A prescaler divides the system clock, and its parameter `SCAN_DIV` sets how many clock cycles each digit stays on. On every prescaler tick the ring moves to the next digit. In each cycle the nibble of the active digit is decoded to active-low segments. The digit enables, the digit select code and the segment lines all come from one output register, so they change on the same clock edge.

Top module: `disp_scan_top`

## Requirements
- R1: After reset, exactly one bit of `dig_en_n_o` is 0 in every cycle.
- R2: `dig_sel_o` steps through 00, 01, 10, 11 and then wraps to 00, moving by exactly one step each time it changes.
- R3: The enables and the select code always form a pair: select 00 with enables 1110, 01 with 1101, 10 with 1011, and 11 with 0111. In each pair, bit k of the enables is low when the select code is k.
- R4: The select code advances exactly once every `SCAN_DIV` clock cycles and holds steady between advances.
- R5: `seg_n_o` carries the active-low decode of nibble `digits_i[4*sel+3:4*sel]`. Bit 0 is segment a and bit 6 is segment g. The glyphs, written in active-high gfedcba form, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R6: Enables, select code and segments are registered together. A change on `digits_i` reaches `seg_n_o` after one clock edge, even while the select code holds.
- R7: Reset is synchronous and active high. It forces select 00, enables 1110, and all segments off (7F). It also clears the prescaler, so the first advance comes `SCAN_DIV` cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digits_i | input | 16 | Four packed hex nibbles, digit k at bits [4k+3:4k] |
| dig_en_n_o | output | 4 | Digit enables, active low, one-cold |
| dig_sel_o | output | 2 | Binary code of the digit currently on |
| seg_n_o | output | 7 | Segments a..g, active low, bit 0 = a |

## Verification
The assertions check, on every cycle, the properties that must hold at all times. Exactly one digit is enabled, and the enable vector matches the select code. The select code only ever moves one step forward, and it holds between prescaler ticks. The prescaler never passes its terminal count, and reset lands in the first digit state. Some properties depend on input values and cycle counts, so only the bench's scenarios can show them. These are the segment glyph for each of the sixteen nibble values, the one-edge latency from `digits_i` to the segments, and the exact spacing of `SCAN_DIV` cycles between advances, both after reset and in steady scanning.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DIGITS = 4;
    localparam int NIB_W  = 4;
    localparam int SEL_W  = $clog2(DIGITS);
    localparam int SEG_W  = 7;
    localparam int DATA_W = DIGITS * NIB_W;

    typedef enum logic [SEL_W-1:0] {
        SCAN_D0 = 2'd0,
        SCAN_D1 = 2'd1,
        SCAN_D2 = 2'd2,
        SCAN_D3 = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic [DIGITS-1:0] en_n;
        logic [SEL_W-1:0]  sel;
        logic [SEG_W-1:0]  seg_n;
    } scan_drive_t;

    localparam logic [SEG_W-1:0] SEG_ALL_OFF = '1;

    // Fixed ring order of the scan
    function automatic scan_state_e ring_step(input scan_state_e s);
        case (s)
            SCAN_D0: return SCAN_D1;
            SCAN_D1: return SCAN_D2;
            SCAN_D2: return SCAN_D3;
            default: return SCAN_D0;
        endcase
    endfunction

    // One-cold enable vector: bit k low selects digit k
    function automatic logic [DIGITS-1:0] enable_pattern(input scan_state_e s);
        return ~(DIGITS'(1) << s);
    endfunction

    // Hex nibble to active-low segments, bit0 = a .. bit6 = g
    function automatic logic [SEG_W-1:0] hex_glyph_n(input logic [NIB_W-1:0] v);
        logic [SEG_W-1:0] lit;
        case (v)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter int SCAN_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(SCAN_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == TERM);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R4: the divider never runs past its terminal count
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TERM);

endmodule

// File: rtl/scan_ring.sv
module scan_ring
    import scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    output scan_state_e state_q,
    output scan_state_e state_nxt
);
    always_comb begin
        state_nxt = tick ? ring_step(state_q) : state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCAN_D0;
        else     state_q <= state_nxt;
    end

    // R4: no movement between ticks
    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_q));

    // R7: reset lands in the first digit state
    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (state_q == SCAN_D0));

endmodule

// File: rtl/scan_drive.sv
module scan_drive
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scan_state_e       state_nxt,
    input  logic [DATA_W-1:0] digits,
    output scan_drive_t       drv_q
);
    logic [NIB_W-1:0] nib;
    scan_drive_t      drv_d;

    always_comb begin
        nib         = digits[NIB_W*int'(state_nxt) +: NIB_W];
        drv_d.en_n  = enable_pattern(state_nxt);
        drv_d.sel   = state_nxt;
        drv_d.seg_n = hex_glyph_n(nib);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q.en_n  <= enable_pattern(SCAN_D0);
            drv_q.sel   <= SCAN_D0;
            drv_q.seg_n <= SEG_ALL_OFF;
        end else begin
            drv_q <= drv_d;
        end
    end

    // R1: exactly one digit switched on
    assert_one_digit_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(~drv_q.en_n) == 1);

    // R3: enable vector and select code belong together
    assert_en_matches_sel_R3: assert property (@(posedge clk) disable iff (rst)
        drv_q.en_n[drv_q.sel] == 1'b0);

    // R7: reset output values
    assert_reset_outputs_R7: assert property (@(posedge clk)
        rst |=> (drv_q.en_n == 4'b1110 && drv_q.sel == 2'b00 && drv_q.seg_n == 7'h7F));

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
    import scan_pkg::*;
#(
    parameter int SCAN_DIV = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] digits_i,
    output logic [3:0]  dig_en_n_o,
    output logic [1:0]  dig_sel_o,
    output logic [6:0]  seg_n_o
);
    logic        tick;
    scan_state_e state_q;
    scan_state_e state_nxt;
    scan_drive_t drv_q;

    scan_prescaler #(.SCAN_DIV(SCAN_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    scan_ring u_ring (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .state_q   (state_q),
        .state_nxt (state_nxt)
    );

    scan_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .state_nxt (state_nxt),
        .digits    (digits_i),
        .drv_q     (drv_q)
    );

    assign dig_en_n_o = drv_q.en_n;
    assign dig_sel_o  = drv_q.sel;
    assign seg_n_o    = drv_q.seg_n;

    // R2: the select code only moves one step forward around the ring
    assert_ring_order_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(dig_sel_o) |-> (dig_sel_o == $past(dig_sel_o) + 2'd1));

    // R6: outputs track the registered ring state
    assert_sel_tracks_state_R6: assert property (@(posedge clk) disable iff (rst)
        dig_sel_o == state_q);

endmodule

// File: tb/tb_disp_scan_top.sv
module tb_disp_scan_top;

    localparam int DIV = 5;

    typedef struct {
        logic [3:0] en_n;
        logic [1:0] sel;
        logic [6:0] seg_n;
        bit         in_reset;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] digits_i = 16'h3210;
    logic [3:0]  dig_en_n_o;
    logic [1:0]  dig_sel_o;
    logic [6:0]  seg_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    exp_t sb_q[$];

    disp_scan_top #(.SCAN_DIV(DIV)) dut (
        .clk        (clk),
        .rst        (rst),
        .digits_i   (digits_i),
        .dig_en_n_o (dig_en_n_o),
        .dig_sel_o  (dig_sel_o),
        .seg_n_o    (seg_n_o)
    );

    always #10 clk = ~clk;

    function automatic logic [6:0] glyph_n(input logic [3:0] v);
        logic [6:0] g;
        case (v)
            4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
            4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
            4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
            4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
        endcase
        return ~g;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Predictor: builds the expected output of each edge from the spec
    int         m_cnt = 0;
    logic [1:0] m_sel = 2'd0;
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_cnt = 0; m_sel = 2'd0;
            e.en_n = 4'b1110; e.sel = 2'd0; e.seg_n = 7'h7F; e.in_reset = 1;
        end else begin
            if (m_cnt == DIV - 1) begin m_cnt = 0; m_sel = m_sel + 2'd1; end
            else m_cnt = m_cnt + 1;
            e.sel = m_sel;
            e.en_n = ~(4'b0001 << m_sel);
            e.seg_n = glyph_n(digits_i[4*m_sel +: 4]);
            e.in_reset = 0;
        end
        sb_q.push_back(e);
    end

    // Monitor: compares each design result against the queued item
    always @(posedge clk) begin
        #5;
        if (!done && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.in_reset) begin
                check(dig_en_n_o == e.en_n && dig_sel_o == e.sel && seg_n_o == e.seg_n,
                      "R7 reset outputs", {dig_en_n_o, dig_sel_o, seg_n_o}, {e.en_n, e.sel, e.seg_n});
            end else begin
                check(dig_en_n_o == e.en_n, "R1 R3 enables", dig_en_n_o, e.en_n);
                check(dig_sel_o == e.sel, "R2 R4 select", dig_sel_o, e.sel);
                check(seg_n_o == e.seg_n, "R5 R6 segments", seg_n_o, e.seg_n);
            end
        end
    end

    task automatic measure_first_advance();
        int n = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #5;
            n++;
            if (dig_sel_o != 2'd0) break;
        end
        check(n == DIV, "R7 R4 first advance spacing", n, DIV);
    endtask

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        measure_first_advance();
        @(negedge clk);
        run(4 * DIV * 2);
        digits_i = 16'h7654;
        run(4 * DIV + 2);
        // change data while the select holds: latency of one edge (R6)
        digits_i = 16'hBA98;
        run(1);
        digits_i = 16'hFEDC;
        run(4 * DIV * 2 + 3);
        // mid-scan reset (R7)
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        measure_first_advance();
        @(negedge clk);
        digits_i = 16'hA5C3;
        run(4 * DIV * 3);
        done = 1;
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule